// File: doc/BRIEF.md
# I2C Target with Byte Register Space

This block is a synchronous I2C target. It runs on the system clock and watches oversampled SCL and SDA lines. Behind it sits a 64-location byte register space. Locations 0 to 6 hold timekeeping values, location 7 holds control bits, and locations 8 to 63 are general-purpose RAM. The block detects START, repeated START and STOP. It answers only to the 7-bit target address 1101000, so the address byte is 0xD0 for a write and 0xD1 for a read. It acknowledges every byte it accepts and steps an internal 6-bit word pointer after each data byte in either direction.

A master can write a pointer and any number of data bytes. It can also write a pointer, issue a repeated START and read. A read with no pointer phase continues from wherever the pointer was left. Only six pointer bits exist, so higher pointer values alias onto the low 64 locations and the pointer wraps from 63 to 0. A timekeeping core reaches the same storage through a simple read/write port. While a power-fail inhibit input is high, the target ignores its address and no register write takes place. The block drives SDA by asserting an output-enable meaning "pull low". Pad modelling, clock stretching and glitch filtering are outside the block.

Top module: `i2c_rf_target`

## Requirements
- R1: After reset the SDA pull-down enable is low, the word pointer is 0 and all 64 locations read 0 on the core port.
- R2: SDA falling while SCL is high starts address reception from any state, including in the middle of a transfer. SDA rising while SCL is high returns the block to idle with SDA released. Data bits are sampled on SCL rising, MSB first.
- R3: The address byte 0xD0 (write) or 0xD1 (read) is acknowledged by driving SDA low through the 9th SCL pulse. Any other address byte is not acknowledged, and the block then drives nothing and writes nothing until the next START.
- R4: The first byte after 0xD0 loads the word pointer from its low 6 bits and is acknowledged. For example, 0x41 selects location 0x01.
- R5: Each further byte after the pointer byte is written at the pointer and acknowledged, and the pointer then increments. There is no byte limit, and the pointer wraps from 0x3F to 0x00.
- R6: After a pointer write, a repeated START and 0xD1, the block sends bytes MSB first starting at the loaded pointer, and the pointer increments after each byte.
- R7: A read addressed with 0xD1 directly after START, without a pointer phase, sends bytes starting at the current pointer. That is the location following the last byte written or read, or 0 after reset.
- R8: A master NACK (SDA high in the 9th clock) after a read byte ends transmission. SDA stays released until the next START or STOP.
- R9: Bits defined as fixed zero always read 0, whatever was written from the bus or the core. These are bit 7 of locations 1 and 2, bits 7..3 of location 3, bits 7..6 of location 4, bits 7..5 of location 5, and bits 6, 3 and 2 of location 7. All other bits of all locations are stored as written.
- R10: While inhibit is high, the address byte is not acknowledged and no register write takes place.
- R11: The core port returns the byte at its address combinationally and writes its data at the clock edge when its write enable is high. When the bus and the core write in the same cycle, the bus write takes effect.
- R12: The SDA pull-down enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| inhibit_i | input | 1 | Power-fail inhibit, high blocks bus access |
| sda_oe_o | output | 1 | High pulls SDA low |
| core_addr_i | input | 6 | Core port location |
| core_we_i | input | 1 | Core port write enable |
| core_wdata_i | input | 8 | Core port write data |
| core_rdata_o | output | 8 | Core port read data |

## Verification
The assertions check the following on every cycle:
- the SDA enable moves only after a synchronized SCL fall, START or STOP;
- START and STOP both leave SDA released;
- no bus write lands while inhibit is high;
- the fixed-zero bits of location 3 read 0.

Only the bench's transfers can show the rest:
- address matching;
- pointer loading and aliasing;
- wrap at 0x3F;
- combined and short reads;
- the release of SDA after a master NACK;
- core and bus sharing the same storage.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } bus_state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } rx_kind_t;

  // Bits that hold state at each location; zeros are read-only zero.
  function automatic logic [BYTE_W-1:0] keep_mask(input int unsigned loc);
    case (loc)
      1, 2:    keep_mask = 8'h7F;
      3:       keep_mask = 8'h07;
      4:       keep_mask = 8'h3F;
      5:       keep_mask = 8'h1F;
      7:       keep_mask = 8'hB3;
      default: keep_mask = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;
  logic              scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs #(
  parameter int unsigned AW = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_we,
  input  logic [AW-1:0]                     bus_addr,
  input  logic [i2c_rf_pkg::BYTE_W-1:0]     bus_wdata,
  output logic [i2c_rf_pkg::BYTE_W-1:0]     bus_rdata,
  input  logic                              core_we,
  input  logic [AW-1:0]                     core_addr,
  input  logic [i2c_rf_pkg::BYTE_W-1:0]     core_wdata,
  output logic [i2c_rf_pkg::BYTE_W-1:0]     core_rdata
);

  localparam int unsigned DW    = i2c_rf_pkg::BYTE_W;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] mem;

  for (genvar i = 0; i < DEPTH; i++) begin : g_loc
    localparam logic [DW-1:0] KMASK = i2c_rf_pkg::keep_mask(i);
    logic          bus_hit, core_hit;
    logic [DW-1:0] q;

    assign bus_hit  = bus_we  && (bus_addr  == AW'(i));
    assign core_hit = core_we && (core_addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (bus_hit)  q <= bus_wdata & KMASK;
      else if (core_hit) q <= core_wdata & KMASK;
    end

    assign mem[i] = q;
  end

  assign bus_rdata  = mem[bus_addr];
  assign core_rdata = mem[core_addr];

endmodule

// File: rtl/i2c_rf_fsm.sv
module i2c_rf_fsm
  import i2c_rf_pkg::*;
#(
  parameter int unsigned AW          = 6,
  parameter logic [6:0]  TARGET_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              inhibit_i,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [AW-1:0]     ptr,
  output logic [BYTE_W-1:0] wr_data
);

  bus_state_t        state, state_n;
  rx_kind_t          kind, kind_n;
  logic [3:0]        cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic [AW-1:0]     ptr_n;
  logic              rw, rw_n, mack, mack_n, oe_n;

  always_comb begin
    state_n = state;
    kind_n  = kind;
    cnt_n   = cnt;
    sh_n    = sh;
    ptr_n   = ptr;
    rw_n    = rw;
    mack_n  = mack;
    oe_n    = sda_oe;
    wr_en   = 1'b0;
    if (start_ev) begin
      state_n = ST_RX;
      kind_n  = K_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else if (stop_ev) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt_n = '0;
            case (kind)
              K_ADDR: begin
                if (sh[7:1] == TARGET_ADDR && !inhibit_i) begin
                  rw_n    = sh[0];
                  kind_n  = K_PTR;
                  oe_n    = 1'b1;
                  state_n = ST_ACK;
                end else begin
                  state_n = ST_WAIT;
                end
              end
              K_PTR: begin
                ptr_n   = sh[AW-1:0];
                kind_n  = K_DATA;
                oe_n    = 1'b1;
                state_n = ST_ACK;
              end
              default: begin
                wr_en   = !inhibit_i;
                ptr_n   = ptr + AW'(1);
                oe_n    = 1'b1;
                state_n = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw) begin
              sh_n    = rd_data;
              ptr_n   = ptr + AW'(1);
              oe_n    = ~rd_data[BYTE_W-1];
              state_n = ST_TX;
            end else begin
              oe_n    = 1'b0;
              state_n = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe_n    = 1'b0;
              state_n = ST_MACK;
            end else begin
              sh_n = {sh[BYTE_W-2:0], 1'b0};
              oe_n = ~sh[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            cnt_n = '0;
            if (mack) begin
              sh_n    = rd_data;
              ptr_n   = ptr + AW'(1);
              oe_n    = ~rd_data[BYTE_W-1];
              state_n = ST_TX;
            end else begin
              state_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind   <= K_ADDR;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      state  <= state_n;
      kind   <= kind_n;
      cnt    <= cnt_n;
      sh     <= sh_n;
      ptr    <= ptr_n;
      rw     <= rw_n;
      mack   <= mack_n;
      sda_oe <= oe_n;
    end
  end

  assign wr_data = sh;

endmodule

// File: rtl/i2c_rf_target.sv
module i2c_rf_target #(
  parameter int unsigned AW          = 6,
  parameter logic [6:0]  TARGET_ADDR = 7'h68,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          inhibit_i,
  output logic          sda_oe_o,
  input  logic [AW-1:0] core_addr_i,
  input  logic          core_we_i,
  input  logic [7:0]    core_wdata_i,
  output logic [7:0]    core_rdata_o
);

  logic          sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic          bus_we;
  logic [AW-1:0] bus_ptr;
  logic [7:0]    bus_wdata, bus_rdata;

  i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_rf_fsm #(.AW(AW), .TARGET_ADDR(TARGET_ADDR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .inhibit_i (inhibit_i),
    .rd_data   (bus_rdata),
    .sda_oe    (sda_oe_o),
    .wr_en     (bus_we),
    .ptr       (bus_ptr),
    .wr_data   (bus_wdata)
  );

  i2c_rf_regs #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_ptr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .core_we    (core_we_i),
    .core_addr  (core_addr_i),
    .core_wdata (core_wdata_i),
    .core_rdata (core_rdata_o)
  );

endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker #(
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_fall,
  input logic          start_ev,
  input logic          stop_ev,
  input logic          sda_oe,
  input logic          wr_en,
  input logic          inhibit,
  input logic [AW-1:0] core_addr,
  input logic [7:0]    core_rdata
);

  // R12: the pull-down enable moves only in response to a SCL fall (or START/STOP)
  p_oe_moves_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));

  // R2: START leaves SDA released
  p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);

  // R2: STOP leaves SDA released
  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R10: no bus write while inhibited
  p_no_write_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !inhibit);

  // R9: fixed-zero bits of location 3
  p_fixed_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_addr == AW'(3)) |-> (core_rdata[7:3] == 5'd0));

endmodule

bind i2c_rf_target i2c_rf_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_fall   (scl_fall),
  .start_ev   (start_ev),
  .stop_ev    (stop_ev),
  .sda_oe     (sda_oe_o),
  .wr_en      (bus_we),
  .inhibit    (inhibit_i),
  .core_addr  (core_addr_i),
  .core_rdata (core_rdata_o)
);

// File: tb/tb_i2c_rf_target.sv
`timescale 1ns/1ps
module tb_i2c_rf_target;

  localparam int Q = 6;

  logic       clk, rst_n;
  logic       scl_m, sda_m, inhibit;
  logic       sda_oe, sda_w;
  logic [5:0] core_addr;
  logic       core_we;
  logic [7:0] core_wdata, core_rdata;

  int   n_chk, n_bad, r12_viol;
  bit   done;
  logic prev_oe;
  logic [7:0] mem_m [0:63];
  logic [5:0] ptr_m;
  logic [7:0] wbuf [0:7];

  assign sda_w = sda_m & ~sda_oe;

  i2c_rf_target dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_w),
    .inhibit_i    (inhibit),
    .sda_oe_o     (sda_oe),
    .core_addr_i  (core_addr),
    .core_we_i    (core_we),
    .core_wdata_i (core_wdata),
    .core_rdata_o (core_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // R12 monitor: pull-down enable must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_oe !== sda_oe) r12_viol++;
    prev_oe = sda_oe;
  end

  function automatic logic [7:0] msk(input int a);
    case (a)
      1: return 8'h7F;
      2: return 8'h7F;
      3: return 8'h07;
      4: return 8'h3F;
      5: return 8'h1F;
      7: return 8'hB3;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; idle(Q);
    scl_m = 1'b1; idle(Q);
    sda_m = 1'b0; idle(Q);
    scl_m = 1'b0; idle(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; idle(Q);
    scl_m = 1'b1; idle(Q);
    sda_m = 1'b1; idle(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; idle(Q);
      scl_m = 1'b1; idle(2 * Q);
      scl_m = 1'b0; idle(Q);
    end
    sda_m = 1'b1; idle(Q);
    scl_m = 1'b1; idle(Q);
    acked = !sda_w;
    idle(Q);
    scl_m = 1'b0; idle(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      idle(Q);
      scl_m = 1'b1; idle(Q);
      b[i] = sda_w;
      idle(Q);
      scl_m = 1'b0;
    end
    idle(Q);
    sda_m = nack; idle(Q);
    scl_m = 1'b1; idle(2 * Q);
    scl_m = 1'b0; idle(Q);
    sda_m = 1'b1;
  endtask

  task automatic core_chk(input string req, input logic [5:0] a);
    core_addr = a;
    idle(1);
    chk(req, core_rdata, mem_m[a]);
  endtask

  task automatic core_wr(input logic [5:0] a, input logic [7:0] d);
    core_addr = a; core_wdata = d; core_we = 1'b1;
    idle(1);
    core_we = 1'b0;
    mem_m[a] = d & msk(a);
  endtask

  task automatic wr_txn(input string req, input logic [7:0] pbyte, input int n);
    bit a;
    logic [5:0] p;
    bus_start();
    send_byte(8'hD0, a); chk("R3 write address ack", {7'd0, a}, 8'd1);
    send_byte(pbyte, a); chk("R4 pointer byte ack", {7'd0, a}, 8'd1);
    p = pbyte[5:0];
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); chk(req, {7'd0, a}, 8'd1);
      mem_m[p] = wbuf[k] & msk(p);
      p = p + 6'd1;
    end
    bus_stop();
    ptr_m = p;
  endtask

  task automatic rd_txn(input string req, input bit combined, input logic [7:0] pbyte, input int n);
    bit a;
    logic [5:0] p;
    logic [7:0] b;
    p = ptr_m;
    bus_start();
    if (combined) begin
      send_byte(8'hD0, a); chk("R3 write address ack", {7'd0, a}, 8'd1);
      send_byte(pbyte, a); chk("R4 pointer byte ack", {7'd0, a}, 8'd1);
      p = pbyte[5:0];
      bus_start();
    end
    send_byte(8'hD1, a); chk("R3 read address ack", {7'd0, a}, 8'd1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, b);
      chk(req, b, mem_m[p]);
      p = p + 6'd1;
    end
    bus_stop();
    ptr_m = p;
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    n_chk = 0; n_bad = 0; r12_viol = 0; done = 0; prev_oe = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; inhibit = 1'b0;
    core_addr = '0; core_we = 1'b0; core_wdata = '0;
    for (int i = 0; i < 64; i++) mem_m[i] = 8'h00;
    ptr_m = '0;
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    chk("R1 sda released after reset", {7'd0, sda_oe}, 8'd0);
    core_chk("R1 reset location 0", 6'd0);
    core_chk("R1 reset location 8", 6'd8);
    core_chk("R1 reset location 63", 6'd63);

    // R7 short read right after reset starts at pointer 0
    rd_txn("R7 short read from reset pointer", 1'b0, 8'h00, 2);

    // R4 aliasing: 0x41 selects 0x01; R9 masks
    for (int k = 0; k < 4; k++) wbuf[k] = 8'hFF;
    wr_txn("R5 data ack", 8'h41, 4);
    core_chk("R4 alias 0x41 lands at 0x01", 6'd1);
    core_chk("R9 fixed zeros location 2", 6'd2);
    core_chk("R9 fixed zeros location 3", 6'd3);
    core_chk("R9 fixed zeros location 4", 6'd4);
    chk("R4 location 0 untouched", mem_m[0], 8'h00);
    core_chk("R4 location 0 untouched", 6'd0);

    // R9 control location and location 5
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
    wr_txn("R5 data ack", 8'h05, 3);
    core_chk("R9 fixed zeros location 5", 6'd5);
    core_chk("R9 location 6 full width", 6'd6);
    core_chk("R9 fixed zeros control location 7", 6'd7);

    // R5 wrap 0x3F -> 0x00
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    wr_txn("R5 data ack", 8'h3E, 4);
    core_chk("R5 write at 0x3E", 6'h3E);
    core_chk("R5 write at 0x3F", 6'h3F);
    core_chk("R5 wrapped write at 0x00", 6'h00);
    core_chk("R5 wrapped write at 0x01", 6'h01);
    chk("R5 pointer after wrap", {2'b0, ptr_m}, 8'h02);

    // R6 combined read across the wrap
    rd_txn("R6 combined read data", 1'b1, 8'h3E, 4);
    // R7 short read continues from pointer 0x02
    rd_txn("R7 short read continues", 1'b0, 8'h00, 2);

    // R3 wrong address: no ack, nothing written
    bus_start();
    send_byte(8'hA0, a); chk("R3 foreign address not acked", {7'd0, a}, 8'd0);
    send_byte(8'h09, a); chk("R3 no ack after foreign address", {7'd0, a}, 8'd0);
    send_byte(8'h77, a); chk("R3 no ack after foreign address", {7'd0, a}, 8'd0);
    bus_stop();
    core_chk("R3 no write after foreign address", 6'h09);

    // R10 inhibit: no address ack, pointer untouched
    inhibit = 1'b1;
    bus_start();
    send_byte(8'hD0, a); chk("R10 address not acked while inhibited", {7'd0, a}, 8'd0);
    send_byte(8'h09, a); chk("R10 pointer byte not acked", {7'd0, a}, 8'd0);
    send_byte(8'h55, a); chk("R10 data byte not acked", {7'd0, a}, 8'd0);
    bus_stop();
    inhibit = 1'b0;
    core_chk("R10 no write while inhibited", 6'h09);
    rd_txn("R10 pointer unchanged after inhibited access", 1'b0, 8'h00, 1);

    // R2 repeated START in the middle of a write
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h30, a); send_byte(8'h11, a);
    mem_m[6'h30] = 8'h11;
    bus_start();
    send_byte(8'hD0, a); chk("R2 address after repeated start acked", {7'd0, a}, 8'd1);
    send_byte(8'h32, a); send_byte(8'h22, a);
    mem_m[6'h32] = 8'h22;
    bus_stop();
    ptr_m = 6'h33;
    core_chk("R2 byte before repeated start", 6'h30);
    core_chk("R2 byte after repeated start", 6'h32);
    core_chk("R2 restart did not write 0x31", 6'h31);

    // R8 master NACK releases SDA; next location holds 0x00 so driving would show
    wbuf[0] = 8'h80; wbuf[1] = 8'h00;
    wr_txn("R5 data ack", 8'h10, 2);
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h10, a);
    bus_start();
    send_byte(8'hD1, a);
    recv_byte(1'b1, b);
    chk("R8 byte before NACK", b, 8'h80);
    begin
      logic [7:0] seen;
      seen = 8'hFF;
      for (int i = 7; i >= 0; i--) begin
        idle(Q); scl_m = 1'b1; idle(Q);
        seen[i] = sda_w;
        idle(Q); scl_m = 1'b0;
      end
      idle(Q);
      chk("R8 SDA released after NACK", seen, 8'hFF);
    end
    bus_stop();
    ptr_m = 6'h11;

    // R11 core port shares storage; masks apply to core writes
    core_wr(6'h20, 8'h5A);
    core_wr(6'h03, 8'hFF);
    core_chk("R11 core write then read", 6'h20);
    core_chk("R9 core write masked", 6'h03);
    rd_txn("R11 bus reads core-written byte", 1'b1, 8'h20, 1);

    // Random mix of writes and reads
    for (int it = 0; it < 10; it++) begin
      automatic int n = 1 + ($urandom % 5);
      automatic logic [7:0] pb = 8'($urandom);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_txn("R5 random write ack", pb, n);
      if ($urandom % 2) rd_txn("R7 random short read", 1'b0, 8'h00, 1 + ($urandom % 3));
      rd_txn("R6 random combined read", 1'b1, 8'($urandom), 1 + ($urandom % 4));
    end
    for (int i = 0; i < 8; i++) core_chk("R9 final contents", 6'(i));

    chk("R12 SDA enable stable while SCL high", 8'(r12_viol), 8'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule